// File: doc/BRIEF.md
# Address-Space-Tagged Translation Cache with Range Invalidation

This block is a small fully associative translation cache for an I/O memory management unit. Every line stores a 7-bit address-space identifier, the virtual page number of a 4 KiB page (virtual address bits 31:12), a 20-bit physical frame number and three permission flags: read, write and non-secure. A client presents an identifier and a 32-bit virtual address. One cycle later it receives hit or miss, the frame number and the permissions. An external page walker fills lines after a miss. New tags go to a round-robin victim slot. A tag that is already cached is rewritten in place.

Software controls the cache through two 32-bit registers on a simple write-only register bus. The configuration register sets how many lines are in use and whether a hit may be served while a miss is still outstanding. The invalidation register removes lines in one write. It can target every line, or the lines inside one 4 MiB section, or the lines inside one 16 KiB group. Each of these can be limited to a single identifier.

Top module: `asid_tlb`

## Requirements
- R1: After reset, no line is valid, `lk_done`, `lk_hit` and `lk_stall` are low, the active line count is 32 (clamped to `ENTRIES`), and serving hits during an outstanding miss is disabled.
- R2: A lookup presented with `lk_valid` high has its result one cycle later with `lk_done` high. It hits when an active valid line holds the same identifier and the same virtual page number (`lk_va[31:12]`). The page offset is ignored. On a hit, `lk_pfn`, `lk_rd`, `lk_wr` and `lk_ns` carry the line's contents. Otherwise they are zero.
- R3: Register address 0 is configuration, and bits 5:0 give the active line count. A count of 0 means 1, and a count above `ENTRIES` means `ENTRIES`. Lines at or above the count are cleared and never hit. A fill of a new tag writes the round-robin slot. The slot then advances and wraps to 0 past the last active line.
- R4: A fill whose identifier and page number already sit in a valid line overwrites that line and leaves the round-robin slot unchanged. No tag is ever held twice.
- R5: A write to register address 1 is an invalidation command. Bit 31 enables identifier matching and bits 30:24 carry the identifier. Bits 1:0 select the range: 0 is all addresses, 2 is a section, 3 is a group, and 1 removes nothing.
- R6: In section mode, a line is removed when its page number bits 19:10 equal command bits 19:10. In group mode, a line is removed when its page number bits 19:2 equal command bits 19:2.
- R7: With bit 31 clear, the identifier is ignored. A command of 0 therefore removes every line.
- R8: An invalidation removes its lines at the end of the write cycle. A lookup in that same cycle does not hit a line being removed. A fill in that same cycle whose own tag matches the command is discarded.
- R9: Configuration bit 29 enables serving hits during a miss. A lookup miss that is not stalled sets a pending flag, and any fill clears it. While the flag is set and bit 29 is clear, a lookup returns `lk_stall` high and `lk_hit` low, and it changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 configuration, 1 invalidation |
| reg_wdata | input | 32 | Register write data |
| lk_valid | input | 1 | Lookup request |
| lk_asid | input | 7 | Lookup address-space identifier |
| lk_va | input | 32 | Lookup virtual address |
| lk_done | output | 1 | Lookup result valid |
| lk_hit | output | 1 | Lookup hit |
| lk_stall | output | 1 | Lookup refused while a miss is pending |
| lk_pfn | output | 20 | Physical frame number of the hit |
| lk_rd | output | 1 | Read permission of the hit |
| lk_wr | output | 1 | Write permission of the hit |
| lk_ns | output | 1 | Non-secure flag of the hit |
| fill_valid | input | 1 | Fill from the page walker |
| fill_asid | input | 7 | Fill identifier |
| fill_vpn | input | 20 | Fill virtual page number |
| fill_pfn | input | 20 | Fill physical frame number |
| fill_rd | input | 1 | Fill read permission |
| fill_wr | input | 1 | Fill write permission |
| fill_ns | input | 1 | Fill non-secure flag |

## Verification
Each lookup result comes out of one register stage and is due exactly one cycle after the request. Fills, invalidations and configuration writes take effect at the edge that ends their own cycle, so a lookup issued in the following cycle sees them. The driver issues one operation per falling edge and pushes the expected outcome of each lookup into a queue. A monitor on the falling edge pops one entry every time `lk_done` is high, which keeps each result tied to its own request. The same-cycle cases drive a lookup or a fill together with an invalidation and predict the result under R8.

// File: rtl/asid_tlb_pkg.sv
package asid_tlb_pkg;

    localparam int ASID_W      = 7;
    localparam int VPN_W       = 20;
    localparam int PFN_W       = 20;
    localparam int REG_W       = 32;
    localparam int CFG_LINES_W = 6;
    localparam int HUM_BIT     = 29;
    localparam int AMATCH_BIT  = 31;
    localparam int ASID_LSB    = 24;
    localparam int SECT_LSB    = 10;  // 4 MiB / 4 KiB = 2^10 pages
    localparam int GRP_LSB     = 2;   // 16 KiB / 4 KiB = 2^2 pages

    typedef enum logic [1:0] {
        FM_ALL  = 2'd0,
        FM_NONE = 2'd1,
        FM_SECT = 2'd2,
        FM_GRP  = 2'd3
    } flush_mode_e;

    typedef struct packed {
        logic              valid;
        logic [ASID_W-1:0] asid;
        logic [VPN_W-1:0]  vpn;
        logic [PFN_W-1:0]  pfn;
        logic              rd;
        logic              wr;
        logic              ns;
    } tlb_entry_t;

    typedef struct packed {
        logic              en;
        logic              asid_en;
        logic [ASID_W-1:0] asid;
        flush_mode_e       mode;
        logic [VPN_W-1:0]  vpn;
    } flush_cmd_t;

    // True when a tag lies inside the range an invalidation command names.
    function automatic logic flush_hits(input logic              valid,
                                        input logic [ASID_W-1:0] asid,
                                        input logic [VPN_W-1:0]  vpn,
                                        input flush_cmd_t        cmd);
        logic id_ok;
        logic rng_ok;
        id_ok = !cmd.asid_en || (asid == cmd.asid);
        case (cmd.mode)
            FM_ALL:  rng_ok = 1'b1;
            FM_SECT: rng_ok = (vpn[VPN_W-1:SECT_LSB] == cmd.vpn[VPN_W-1:SECT_LSB]);
            FM_GRP:  rng_ok = (vpn[VPN_W-1:GRP_LSB] == cmd.vpn[VPN_W-1:GRP_LSB]);
            default: rng_ok = 1'b0;
        endcase
        return cmd.en && valid && id_ok && rng_ok;
    endfunction

endpackage

// File: rtl/asid_tlb_regs.sv
module asid_tlb_regs
    import asid_tlb_pkg::*;
#(
    parameter int ENTRIES   = 32,
    parameter int DEF_LINES = 32,
    localparam int CNT_W    = $clog2(ENTRIES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [1:0]       reg_addr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [CNT_W-1:0] active_cnt,
    output logic             hum_en,
    output flush_cmd_t       flush_cmd
);

    localparam logic [1:0] ADDR_CFG   = 2'd0;
    localparam logic [1:0] ADDR_FLUSH = 2'd1;

    typedef struct packed {
        logic [CFG_LINES_W-1:0] lines;
        logic                   hum;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (reg_wr && reg_addr == ADDR_CFG) begin
            cfg_d.lines = reg_wdata[CFG_LINES_W-1:0];
            cfg_d.hum   = reg_wdata[HUM_BIT];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q.lines <= CFG_LINES_W'(DEF_LINES);
            cfg_q.hum   <= 1'b0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    // clamp the programmed count into 1..ENTRIES
    always_comb begin
        if (cfg_q.lines == '0)
            active_cnt = CNT_W'(1);
        else if (int'(cfg_q.lines) > ENTRIES)
            active_cnt = CNT_W'(ENTRIES);
        else
            active_cnt = CNT_W'(cfg_q.lines);
    end

    assign hum_en = cfg_q.hum;

    always_comb begin
        flush_cmd.en      = reg_wr && (reg_addr == ADDR_FLUSH);
        flush_cmd.asid_en = reg_wdata[AMATCH_BIT];
        flush_cmd.asid    = reg_wdata[ASID_LSB +: ASID_W];
        flush_cmd.mode    = flush_mode_e'(reg_wdata[1:0]);
        flush_cmd.vpn     = reg_wdata[VPN_W-1:0];
    end

    logic regs_unused;
    assign regs_unused = ^reg_wdata[ASID_LSB-1:VPN_W];

    // R3
    lines_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active_cnt != '0) && (int'(active_cnt) <= ENTRIES));

endmodule

// File: rtl/asid_tlb_line_cmp.sv
module asid_tlb_line_cmp
    import asid_tlb_pkg::*;
(
    input  tlb_entry_t        ent,
    input  logic              in_range,
    input  logic [ASID_W-1:0] lk_asid,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic [ASID_W-1:0] fill_asid,
    input  logic [VPN_W-1:0]  fill_vpn,
    input  flush_cmd_t        flush_cmd,
    output logic              lk_hit,
    output logic              fill_hit,
    output logic              flush_hit
);

    logic tag_lk;
    logic tag_fill;

    always_comb begin
        tag_lk    = ent.valid && (ent.asid == lk_asid) && (ent.vpn == lk_vpn);
        tag_fill  = ent.valid && (ent.asid == fill_asid) && (ent.vpn == fill_vpn);
        flush_hit = flush_hits(ent.valid, ent.asid, ent.vpn, flush_cmd);
        // a line being invalidated this cycle must not answer a lookup
        lk_hit    = in_range && tag_lk && !flush_hit;
        fill_hit  = in_range && tag_fill;
    end

    logic line_unused;
    assign line_unused = ^{ent.pfn, ent.rd, ent.wr, ent.ns};

endmodule

// File: rtl/asid_tlb_victim.sv
module asid_tlb_victim #(
    parameter int ENTRIES = 32,
    localparam int IDX_W  = $clog2(ENTRIES),
    localparam int CNT_W  = $clog2(ENTRIES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             advance,
    input  logic [CNT_W-1:0] active_cnt,
    output logic [IDX_W-1:0] ptr
);

    logic [IDX_W-1:0] ptr_d, ptr_q;

    always_comb begin
        // a pointer left beyond a shrunken window restarts at slot 0
        ptr   = (int'(ptr_q) < int'(active_cnt)) ? ptr_q : '0;
        ptr_d = ptr;
        if (advance) begin
            if (int'(ptr) + 1 >= int'(active_cnt))
                ptr_d = '0;
            else
                ptr_d = ptr + IDX_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    // R3
    ptr_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        advance |=> (int'(ptr_q) < int'($past(active_cnt))));

endmodule

// File: rtl/asid_tlb.sv
module asid_tlb
    import asid_tlb_pkg::*;
#(
    parameter int ENTRIES   = 32,
    parameter int DEF_LINES = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    input  logic              lk_valid,
    input  logic [6:0]        lk_asid,
    input  logic [31:0]       lk_va,
    output logic              lk_done,
    output logic              lk_hit,
    output logic              lk_stall,
    output logic [19:0]       lk_pfn,
    output logic              lk_rd,
    output logic              lk_wr,
    output logic              lk_ns,
    input  logic              fill_valid,
    input  logic [6:0]        fill_asid,
    input  logic [19:0]       fill_vpn,
    input  logic [19:0]       fill_pfn,
    input  logic              fill_rd,
    input  logic              fill_wr,
    input  logic              fill_ns
);

    localparam int IDX_W = $clog2(ENTRIES);
    localparam int CNT_W = $clog2(ENTRIES + 1);
    localparam int PAGE_SHIFT = 32 - VPN_W;

    typedef struct packed {
        tlb_entry_t [ENTRIES-1:0] ent;
        logic                     pend;
        logic                     done;
        logic                     hit;
        logic                     stall;
        logic [PFN_W-1:0]         pfn;
        logic                     rd;
        logic                     wr;
        logic                     ns;
    } st_t;

    st_t st_d, st_q;

    logic [CNT_W-1:0] active_cnt;
    logic             hum_en;
    flush_cmd_t       flush_cmd;
    logic [IDX_W-1:0] victim_ptr;
    logic             advance;

    logic [VPN_W-1:0]   lk_vpn;
    logic [ENTRIES-1:0] lk_vec;
    logic [ENTRIES-1:0] fill_vec;
    logic [ENTRIES-1:0] fl_vec;

    assign lk_vpn = lk_va[31:PAGE_SHIFT];

    asid_tlb_regs #(
        .ENTRIES   (ENTRIES),
        .DEF_LINES (DEF_LINES)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr     (reg_wr),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .active_cnt (active_cnt),
        .hum_en     (hum_en),
        .flush_cmd  (flush_cmd)
    );

    asid_tlb_victim #(
        .ENTRIES (ENTRIES)
    ) u_victim (
        .clk        (clk),
        .rst_n      (rst_n),
        .advance    (advance),
        .active_cnt (active_cnt),
        .ptr        (victim_ptr)
    );

    for (genvar g = 0; g < ENTRIES; g++) begin : g_line
        asid_tlb_line_cmp u_cmp (
            .ent       (st_q.ent[g]),
            .in_range  (g < int'(active_cnt)),
            .lk_asid   (lk_asid),
            .lk_vpn    (lk_vpn),
            .fill_asid (fill_asid),
            .fill_vpn  (fill_vpn),
            .flush_cmd (flush_cmd),
            .lk_hit    (lk_vec[g]),
            .fill_hit  (fill_vec[g]),
            .flush_hit (fl_vec[g])
        );
    end

    logic             stall_now;
    logic             hit_any;
    logic             fill_known;
    logic             fill_drop;
    logic [IDX_W-1:0] fill_idx;
    logic [IDX_W-1:0] fill_tgt;
    tlb_entry_t       sel;
    tlb_entry_t       fill_ent;

    always_comb begin
        st_d      = st_q;
        stall_now = st_q.pend && !hum_en;
        hit_any   = |lk_vec;
        fill_known = |fill_vec;
        fill_drop = flush_hits(1'b1, fill_asid, fill_vpn, flush_cmd);

        sel      = '0;
        fill_idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (lk_vec[i])   sel = sel | st_q.ent[i];
            if (fill_vec[i]) fill_idx = IDX_W'(i);
        end
        fill_tgt = fill_known ? fill_idx : victim_ptr;
        advance  = fill_valid && !fill_drop && !fill_known;

        fill_ent.valid = 1'b1;
        fill_ent.asid  = fill_asid;
        fill_ent.vpn   = fill_vpn;
        fill_ent.pfn   = fill_pfn;
        fill_ent.rd    = fill_rd;
        fill_ent.wr    = fill_wr;
        fill_ent.ns    = fill_ns;

        for (int i = 0; i < ENTRIES; i++) begin
            if (fl_vec[i] || i >= int'(active_cnt))
                st_d.ent[i].valid = 1'b0;
            if (fill_valid && !fill_drop && IDX_W'(i) == fill_tgt)
                st_d.ent[i] = fill_ent;
        end

        st_d.done  = lk_valid;
        st_d.stall = lk_valid && stall_now;
        st_d.hit   = lk_valid && !stall_now && hit_any;
        st_d.pfn   = st_d.hit ? sel.pfn : '0;
        st_d.rd    = st_d.hit && sel.rd;
        st_d.wr    = st_d.hit && sel.wr;
        st_d.ns    = st_d.hit && sel.ns;

        if (fill_valid)
            st_d.pend = 1'b0;
        if (lk_valid && !stall_now && !hit_any)
            st_d.pend = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lk_done  = st_q.done;
    assign lk_hit   = st_q.hit;
    assign lk_stall = st_q.stall;
    assign lk_pfn   = st_q.pfn;
    assign lk_rd    = st_q.rd;
    assign lk_wr    = st_q.wr;
    assign lk_ns    = st_q.ns;

    logic top_unused;
    assign top_unused = ^lk_va[PAGE_SHIFT-1:0];

    // R2
    result_due_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> lk_done);

    // R2
    result_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !lk_done);

    // R4
    single_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_vec));

    // R9
    hum_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && st_q.pend && !hum_en) |=> (lk_stall && !lk_hit));

    // R7
    flush_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 2'd1 && !reg_wdata[31] && reg_wdata[1:0] == 2'd0)
        ##1 lk_valid |=> !lk_hit);

endmodule

// File: tb/asid_tlb_test.sv
module asid_tlb_test;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int K_HIT   = 0;
    localparam int K_MISS  = 1;
    localparam int K_STALL = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic        lk_valid = 1'b0;
    logic [6:0]  lk_asid = '0;
    logic [31:0] lk_va = '0;
    logic        lk_done, lk_hit, lk_stall, lk_rd, lk_wr, lk_ns;
    logic [19:0] lk_pfn;
    logic        fill_valid = 1'b0;
    logic [6:0]  fill_asid = '0;
    logic [19:0] fill_vpn = '0;
    logic [19:0] fill_pfn = '0;
    logic        fill_rd = 1'b0, fill_wr = 1'b0, fill_ns = 1'b0;

    always #2.5 clk = ~clk;

    asid_tlb uut (.*);

    typedef struct {
        int          kind;
        logic [19:0] pfn;
        logic [2:0]  perm;
        string       tag;
    } exp_t;

    exp_t sb[$];
    int   n_chk = 0;
    int   n_bad = 0;
    bit   finished = 1'b0;

    task automatic check(input bit ok, input string req, input logic [24:0] act,
                         input logic [24:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor: one queued expectation per delivered result
    always @(negedge clk) begin
        if (rst_n && lk_done) begin
            logic [24:0] act;
            logic [24:0] exp;
            act = {lk_hit, lk_stall, lk_pfn, lk_rd, lk_wr, lk_ns};
            if (sb.size() == 0) begin
                check(1'b0, "R2 unexpected result", act, '0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                case (e.kind)
                    K_HIT:   exp = {1'b1, 1'b0, e.pfn, e.perm};
                    K_STALL: exp = {1'b0, 1'b1, 20'h0, 3'b000};
                    default: exp = '0;
                endcase
                check(act == exp, e.tag, act, exp);
            end
        end
    end

    task automatic tick();
        @(negedge clk);
        lk_valid   = 1'b0;
        fill_valid = 1'b0;
        reg_wr     = 1'b0;
    endtask

    task automatic set_lookup(input logic [6:0] a, input logic [31:0] va, input int kind,
                              input logic [19:0] pfn, input logic [2:0] perm,
                              input string tag);
        exp_t e;
        lk_valid = 1'b1;
        lk_asid  = a;
        lk_va    = va;
        e.kind = kind;
        e.pfn  = pfn;
        e.perm = perm;
        e.tag  = tag;
        sb.push_back(e);
    endtask

    task automatic set_fill(input logic [6:0] a, input logic [19:0] vpn,
                            input logic [19:0] pfn, input logic [2:0] perm);
        fill_valid = 1'b1;
        fill_asid  = a;
        fill_vpn   = vpn;
        fill_pfn   = pfn;
        {fill_rd, fill_wr, fill_ns} = perm;
    endtask

    task automatic set_write(input logic [1:0] addr, input logic [31:0] data);
        reg_wr    = 1'b1;
        reg_addr  = addr;
        reg_wdata = data;
    endtask

    task automatic hit(input logic [6:0] a, input logic [19:0] vpn, input logic [19:0] pfn,
                       input string tag);
        set_lookup(a, {vpn, 12'h000}, K_HIT, pfn, 3'b111, tag);
        tick();
    endtask

    task automatic miss(input logic [6:0] a, input logic [19:0] vpn, input string tag);
        set_lookup(a, {vpn, 12'h000}, K_MISS, '0, '0, tag);
        tick();
    endtask

    task automatic fill(input logic [6:0] a, input logic [19:0] vpn, input logic [19:0] pfn);
        set_fill(a, vpn, pfn, 3'b111);
        tick();
    endtask

    task automatic wr(input logic [1:0] addr, input logic [31:0] data);
        set_write(addr, data);
        tick();
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset outputs
        check({lk_done, lk_hit, lk_stall} == 3'b000, "R1 reset outputs",
              {22'h0, lk_done, lk_hit, lk_stall}, '0);

        // R1 R3: default of 32 lines, 33 fills wrap the pointer to slot 0
        for (int i = 0; i <= 32; i++) fill(7'd1, 20'(i), 20'h100 + 20'(i));
        hit(7'd1, 20'd1, 20'h101, "R2 hit after fill");
        miss(7'd1, 20'd0, "R1 R3 oldest line evicted at 32 lines");
        set_lookup(7'd1, {20'd2, 12'h000}, K_STALL, '0, '0, "R9 stall while miss pending");
        tick();
        fill(7'd1, 20'd0, 20'h200);
        hit(7'd1, 20'd0, 20'h200, "R9 fill clears pending");
        miss(7'd1, 20'd1, "R3 round robin evicts next slot");
        wr(2'd0, 32'h2000_0020);
        hit(7'd1, 20'd2, 20'h102, "R9 hit under miss enabled");
        set_lookup(7'd1, {20'd2, 12'hABC}, K_HIT, 20'h102, 3'b111, "R2 offset ignored");
        tick();
        miss(7'd2, 20'd2, "R2 identifier mismatch");

        // R7 everything
        wr(2'd1, 32'h0000_0000);
        miss(7'd1, 20'd2, "R7 flush all");
        miss(7'd1, 20'd0, "R7 flush all");

        // R3 four active lines, pointer at slot 2
        wr(2'd0, 32'h2000_0004);
        for (int i = 0; i < 5; i++) fill(7'd2, 20'h10 + 20'(i), 20'h310 + 20'(i));
        miss(7'd2, 20'h10, "R3 four-line window wraps");
        hit(7'd2, 20'h11, 20'h311, "R3 four-line window");
        hit(7'd2, 20'h14, 20'h314, "R3 four-line window");

        // R4 in-place update
        set_fill(7'd2, 20'h11, 20'h333, 3'b100);
        tick();
        set_lookup(7'd2, {20'h11, 12'h000}, K_HIT, 20'h333, 3'b100, "R4 updated in place");
        tick();
        fill(7'd2, 20'h15, 20'h315);
        miss(7'd2, 20'h11, "R4 pointer not advanced by update");
        hit(7'd2, 20'h12, 20'h312, "R4 other lines kept");
        hit(7'd2, 20'h15, 20'h315, "R4 new tag placed");

        // R5 R6 ranged and identifier-limited flushes
        wr(2'd0, 32'h2000_0020);
        wr(2'd1, 32'h0000_0000);
        fill(7'd3, 20'h400, 20'h00400);
        fill(7'd3, 20'h401, 20'h00401);
        fill(7'd3, 20'h404, 20'h00404);
        fill(7'd3, 20'h800, 20'h00800);
        fill(7'd4, 20'h400, 20'h04400);
        wr(2'd1, 32'h8300_0403);
        miss(7'd3, 20'h400, "R6 group flush");
        miss(7'd3, 20'h401, "R6 group flush");
        hit(7'd3, 20'h404, 20'h00404, "R6 outside group");
        hit(7'd3, 20'h800, 20'h00800, "R6 outside group");
        hit(7'd4, 20'h400, 20'h04400, "R5 other identifier kept");
        wr(2'd1, 32'h8400_0402);
        miss(7'd4, 20'h400, "R6 section flush");
        hit(7'd3, 20'h404, 20'h00404, "R5 section limited by identifier");
        wr(2'd1, 32'h8300_0000);
        miss(7'd3, 20'h404, "R5 identifier flush");
        miss(7'd3, 20'h800, "R5 identifier flush");

        // R7 section flush without identifier
        fill(7'd4, 20'h400, 20'h04400);
        fill(7'd5, 20'h403, 20'h05403);
        fill(7'd5, 20'h800, 20'h05800);
        wr(2'd1, 32'h0000_0402);
        miss(7'd4, 20'h400, "R7 identifier ignored");
        miss(7'd5, 20'h403, "R7 identifier ignored");
        hit(7'd5, 20'h800, 20'h05800, "R7 other section kept");

        // R8 same-cycle interactions
        set_lookup(7'd5, {20'h800, 12'h000}, K_MISS, '0, '0, "R8 lookup during flush");
        set_write(2'd1, 32'h8500_0000);
        tick();
        miss(7'd5, 20'h800, "R8 flush applied");
        fill(7'd6, 20'h900, 20'h06900);
        set_lookup(7'd6, {20'h900, 12'h000}, K_HIT, 20'h06900, 3'b111, "R8 unrelated flush");
        set_write(2'd1, 32'h8700_0000);
        tick();
        set_fill(7'd6, 20'h901, 20'h06901, 3'b111);
        set_write(2'd1, 32'h8600_0000);
        tick();
        miss(7'd6, 20'h901, "R8 fill dropped by flush");
        miss(7'd6, 20'h900, "R8 flush applied");

        // R5 reserved mode removes nothing
        fill(7'd6, 20'h902, 20'h06902);
        wr(2'd1, 32'h0000_0001);
        hit(7'd6, 20'h902, 20'h06902, "R5 reserved mode");

        repeat (3) tick();
        check(sb.size() == 0, "R2 all results delivered", 25'(sb.size()), '0);
        finished = 1'b1;
        summary();
        $finish;
    end

endmodule